// File: doc/BRIEF.md
# Data Register File With Pointer-Based Access

This block is the 32-location, byte-wide data register file of a small accumulator processor. A single 5-bit address space holds a handful of control registers at the low end and general purpose storage at the top. Location 00h has no storage of its own. Any access to it is steered to the location named by a 5-bit pointer register at 04h, which lets software walk through storage with a loop. When the pointer itself holds 00h, the access does nothing: a read returns 00h and a write changes nothing.

The condition register at 03h combines three kinds of bit. Some are plain writable bits. Three ALU flags can be loaded by an explicit write or by the flag logic, and the flag logic wins whenever the current instruction updates that flag. Two power-state bits cannot be written by instructions and change only on sleep and watchdog events. A 4-bit output port latch sits at 06h. Reading 06h returns the live input pins, not the latch. Every other low address reads 00h and ignores writes.

Reads are combinational from the read address. Writes take effect on the rising clock edge when write enable is high. The amount of storage is set by a parameter: 16 bytes at 10h–1Fh, or 24 bytes at 08h–1Fh.

Top module: `ind_regfile`

## Requirements
- R1: After synchronous reset, the condition register reads 18h (bit4 timeout flag = 1, bit3 power-down flag = 1, all other bits 0), the pointer reads E0h, and the port latch is 0.
- R2: Storage occupies the top GPR_BYTES addresses (10h–1Fh for the default of 16). A byte written there reads back unchanged.
- R3: An access to address 00h is performed at the address held in the pointer. This applies to reads and to writes, including writes that reach the condition register.
- R4: When the pointer holds 00h, a read of 00h returns 00h, and a write to 00h leaves every register, the storage and the port latch unchanged.
- R5: The pointer at 04h stores bits 4:0 of the write data. It reads back with bits 7:5 forced to 1.
- R6: The condition register has flags in bits 2:0 (bit2 zero, bit1 digit carry, bit0 carry). For each flag whose bit is set in flag_mask, the flag takes flag_val in that cycle and any explicit write to the bit is ignored. For each unmasked flag, an explicit write loads the data bit. Bits 7:5 load from an explicit write.
- R7: Bits 4 (timeout) and 3 (power-down) of the condition register keep their value across explicit writes.
- R8: sleep_evt clears the power-down bit. wdt_timeout clears the timeout bit. wdt_clear sets both bits, except that a clearing event in the same cycle takes priority for its own bit.
- R9: A write to 06h loads the port latch from bits 3:0. A read of 06h returns pin_in in bits 3:0 and 0 in bits 7:4.
- R10: Addresses 01h, 02h, 05h, 07h, and addresses below the storage (08h–0Fh at the default size), read 00h and ignore writes. A write to 08h does not alias into the storage.
- R11: A write becomes visible at the read port only after the clock edge on which write enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| flag_mask | input | 3 | Flags updated by the current instruction (bit2 Z, bit1 DC, bit0 C) |
| flag_val | input | 3 | New flag values from the ALU |
| sleep_evt | input | 1 | Sleep executed; clears power-down bit |
| wdt_timeout | input | 1 | Watchdog expired; clears timeout bit |
| wdt_clear | input | 1 | Watchdog cleared; sets timeout and power-down bits |
| pin_in | input | 4 | Input pin levels read at 06h |
| port_latch | output | 4 | Output port latch |

## Verification
The bench targets four corner cases, each with the failure it would expose:
- Pointer self-reference. A design that decodes the pointer one level deep would read back the pointer value itself instead of 00h. A write through it would corrupt the pointer or the port.
- A condition-register write that coincides with a flag update. A design that gives the write priority leaves the wrong zero or carry value. A design that lets the write reach bits 4:3 lets software forge the power-state bits.
- Simultaneous clear and sleep events. These show whether the clearing event is allowed to win its own bit.
- Writes to 08h at the 16-byte size. A missing range check would wrap them into storage, and a later read at 18h would show the stray byte.

// File: rtl/ind_rf_pkg.sv
package ind_rf_pkg;
  localparam int RF_AW = 5;
  localparam int RF_DW = 8;

  localparam logic [RF_AW-1:0] A_INDIRECT = 5'h00;
  localparam logic [RF_AW-1:0] A_STATUS   = 5'h03;
  localparam logic [RF_AW-1:0] A_POINTER  = 5'h04;
  localparam logic [RF_AW-1:0] A_PORT     = 5'h06;

  typedef struct packed {
    logic [2:0] wake;   // software-writable upper bits
    logic       to;     // timeout flag
    logic       pd;     // power-down flag
    logic [2:0] alu;    // Z, DC, C
  } cond_t;
endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] pointer,
  output logic [AW-1:0] eff,
  output logic          null_sel
);
  always_comb begin
    eff      = (addr == '0) ? pointer : addr;
    null_sel = (eff == '0);
  end
endmodule

// File: rtl/rf_gpr_ram.sv
module rf_gpr_ram #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int BASE = (1 << AW) - DEPTH;
  localparam int IW   = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic          w_hit, r_hit;
  logic [IW-1:0] widx, ridx;

  assign w_hit = (waddr >= AW'(BASE));
  assign r_hit = (raddr >= AW'(BASE));
  assign widx  = IW'(waddr - AW'(BASE));
  assign ridx  = IW'(raddr - AW'(BASE));

  always_ff @(posedge clk) begin
    if (we && w_hit) mem[widx] <= wdata;
  end

  assign rdata = r_hit ? mem[ridx] : '0;
endmodule

// File: rtl/rf_cond_reg.sv
module rf_cond_reg
  import ind_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [2:0] flag_mask,
  input  logic [2:0] flag_val,
  input  logic       sleep_evt,
  input  logic       wdt_timeout,
  input  logic       wdt_clear,
  output cond_t      cond
);
  logic [2:0] alu_n;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      if (flag_mask[i])  alu_n[i] = flag_val[i];
      else if (wr_en)    alu_n[i] = wr_data[i];
      else               alu_n[i] = cond.alu[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond <= '{wake: 3'b000, to: 1'b1, pd: 1'b1, alu: 3'b000};
    end else begin
      if (wr_en) cond.wake <= wr_data[7:5];
      cond.alu <= alu_n;
      if (wdt_timeout)    cond.to <= 1'b0;
      else if (wdt_clear) cond.to <= 1'b1;
      if (sleep_evt)      cond.pd <= 1'b0;
      else if (wdt_clear) cond.pd <= 1'b1;
    end
  end

  // R7: power-state bits only move on events
  a_r7_power_bits_locked: assert property (@(posedge clk) disable iff (rst)
    (!sleep_evt && !wdt_timeout && !wdt_clear) |=> $stable({cond.to, cond.pd}));

  // R6: masked flags follow the ALU regardless of writes
  a_r6_flag_logic_wins: assert property (@(posedge clk) disable iff (rst)
    (flag_mask != 3'b000) |=> (((cond.alu ^ $past(flag_val)) & $past(flag_mask)) == 3'b000));

  // R8: sleep clears power-down
  a_r8_sleep_clears_pd: assert property (@(posedge clk) disable iff (rst)
    sleep_evt |=> !cond.pd);

  // R8: timeout clears timeout flag
  a_r8_timeout_clears_to: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> !cond.to);
endmodule

// File: rtl/ind_regfile.sv
module ind_regfile
  import ind_rf_pkg::*;
#(
  parameter int GPR_BYTES = 16,
  parameter int PORT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RF_AW-1:0]  rd_addr,
  output logic [RF_DW-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [RF_AW-1:0]  wr_addr,
  input  logic [RF_DW-1:0]  wr_data,
  input  logic [2:0]        flag_mask,
  input  logic [2:0]        flag_val,
  input  logic              sleep_evt,
  input  logic              wdt_timeout,
  input  logic              wdt_clear,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] port_latch
);
  localparam int PTR_PAD = RF_DW - RF_AW;
  localparam int PIN_PAD = RF_DW - PORT_W;

  logic [RF_AW-1:0]  ptr_q;
  logic [PORT_W-1:0] port_q;
  logic [RF_AW-1:0]  r_eff, w_eff;
  logic              r_null, w_null;
  logic              wr_ok, cond_we;
  logic [RF_DW-1:0]  ram_rdata;
  cond_t             cond;

  rf_addr_resolve #(.AW(RF_AW)) u_rd_res (
    .addr(rd_addr), .pointer(ptr_q), .eff(r_eff), .null_sel(r_null));

  rf_addr_resolve #(.AW(RF_AW)) u_wr_res (
    .addr(wr_addr), .pointer(ptr_q), .eff(w_eff), .null_sel(w_null));

  assign wr_ok   = wr_en && !w_null;
  assign cond_we = wr_ok && (w_eff == A_STATUS);

  rf_cond_reg u_cond (
    .clk(clk), .rst(rst), .wr_en(cond_we), .wr_data(wr_data),
    .flag_mask(flag_mask), .flag_val(flag_val),
    .sleep_evt(sleep_evt), .wdt_timeout(wdt_timeout), .wdt_clear(wdt_clear),
    .cond(cond));

  rf_gpr_ram #(.AW(RF_AW), .DW(RF_DW), .DEPTH(GPR_BYTES)) u_ram (
    .clk(clk), .we(wr_ok), .waddr(w_eff), .wdata(wr_data),
    .raddr(r_eff), .rdata(ram_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      port_q <= '0;
    end else if (wr_ok) begin
      if (w_eff == A_POINTER) ptr_q  <= wr_data[RF_AW-1:0];
      if (w_eff == A_PORT)    port_q <= wr_data[PORT_W-1:0];
    end
  end

  always_comb begin
    if (r_null) begin
      rd_data = '0;
    end else begin
      case (r_eff)
        A_STATUS:  rd_data = cond;
        A_POINTER: rd_data = {{PTR_PAD{1'b1}}, ptr_q};
        A_PORT:    rd_data = {{PIN_PAD{1'b0}}, pin_in};
        default:   rd_data = ram_rdata;
      endcase
    end
  end

  assign port_latch = port_q;

  // R4: self-referencing read yields zero
  a_r4_null_read: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_INDIRECT && ptr_q == A_INDIRECT) |-> (rd_data == '0));

  // R4: self-referencing write leaves state alone
  a_r4_null_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_INDIRECT && ptr_q == A_INDIRECT && flag_mask == 3'b000
     && !sleep_evt && !wdt_timeout && !wdt_clear)
    |=> ($stable(ptr_q) && $stable(port_q) && $stable(cond)));

  // R5: pointer upper bits read as ones
  a_r5_pointer_upper_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_POINTER) |-> (rd_data[RF_DW-1:RF_AW] == '1));

  // R9: port read upper bits are zero
  a_r9_port_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_PORT) |-> (rd_data[RF_DW-1:PORT_W] == '0));
endmodule

// File: tb/ind_regfile_tb.sv
module ind_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  // vector: {write, addr[4:0], data[7:0], req[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 5'h10, 8'hA5, 8'd2}, {1'b1, 5'h1F, 8'h3C, 8'd2},   // R2
    {1'b0, 5'h10, 8'hA5, 8'd2}, {1'b0, 5'h1F, 8'h3C, 8'd2},
    {1'b1, 5'h04, 8'h1F, 8'd5}, {1'b0, 5'h04, 8'hFF, 8'd5},   // R5
    {1'b0, 5'h00, 8'h3C, 8'd3}, {1'b1, 5'h00, 8'h77, 8'd3},   // R3
    {1'b0, 5'h1F, 8'h77, 8'd3},
    {1'b1, 5'h04, 8'h0A, 8'd5}, {1'b0, 5'h04, 8'hEA, 8'd5},
    {1'b1, 5'h18, 8'h11, 8'd10}, {1'b1, 5'h08, 8'h99, 8'd10}, // R10
    {1'b0, 5'h08, 8'h00, 8'd10}, {1'b0, 5'h18, 8'h11, 8'd10},
    {1'b0, 5'h01, 8'h00, 8'd10}, {1'b1, 5'h07, 8'h42, 8'd10},
    {1'b0, 5'h07, 8'h00, 8'd10},
    {1'b1, 5'h06, 8'hFF, 8'd9}, {1'b0, 5'h06, 8'h0A, 8'd9},   // R9
    {1'b1, 5'h04, 8'h00, 8'd4}, {1'b0, 5'h00, 8'h00, 8'd4},   // R4
    {1'b1, 5'h00, 8'h55, 8'd4}, {1'b0, 5'h04, 8'hE0, 8'd4},
    {1'b0, 5'h10, 8'hA5, 8'd4}, {1'b0, 5'h1F, 8'h77, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] flag_mask = '0;
  logic [2:0] flag_val = '0;
  logic       sleep_evt = 1'b0;
  logic       wdt_timeout = 1'b0;
  logic       wdt_clear = 1'b0;
  logic [3:0] pin_in = 4'hA;
  logic [3:0] port_latch;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_regfile u_dut (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_mask(flag_mask), .flag_val(flag_val),
    .sleep_evt(sleep_evt), .wdt_timeout(wdt_timeout), .wdt_clear(wdt_clear),
    .pin_in(pin_in), .port_latch(port_latch));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic [4:0] a, input logic [7:0] d,
                     input logic [2:0] m, input logic [2:0] fv,
                     input logic slp, input logic tmo, input logic clr);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; flag_mask = m; flag_val = fv;
    sleep_evt = slp; wdt_timeout = tmo; wdt_clear = clr;
    @(posedge clk);
    #1;
    wr_en = 1'b0; flag_mask = '0; flag_val = '0;
    sleep_evt = 1'b0; wdt_timeout = 1'b0; wdt_clear = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    rd("R1", 5'h03, 8'h18);
    rd("R1", 5'h04, 8'hE0);
    chk("R1", {4'h0, port_latch}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][21])
        cyc(1'b1, VEC[i][20:16], VEC[i][15:8], 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
      else
        rd($sformatf("R%0d", VEC[i][7:0]), VEC[i][20:16], VEC[i][15:8]);
    end
    // R9 latch from the table write of FFh; R4 null write left it intact
    chk("R9", {4'h0, port_latch}, 8'h0F);

    // R11 write visible only after the edge
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'h10; wr_data = 8'h5A; rd_addr = 5'h10;
    #1 chk("R11", rd_data, 8'hA5);
    @(posedge clk);
    #1 wr_en = 1'b0;
    chk("R11", rd_data, 8'h5A);

    // R8 sleep clears power-down
    cyc(1'b0, 5'h00, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0, 1'b0);
    rd("R8", 5'h03, 8'h10);
    // R7 power bits survive an all-ones write
    cyc(1'b1, 5'h03, 8'hFF, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
    rd("R7", 5'h03, 8'hF7);
    // R6 clear with zero flag forced: 000u u1uu
    cyc(1'b1, 5'h03, 8'h00, 3'b100, 3'b100, 1'b0, 1'b0, 1'b0);
    rd("R6", 5'h03, 8'h14);
    // R6 carry masked, others from write
    cyc(1'b1, 5'h03, 8'hFF, 3'b001, 3'b000, 1'b0, 1'b0, 1'b0);
    rd("R6", 5'h03, 8'hF6);
    // R6 flag update with no write
    cyc(1'b0, 5'h03, 8'h00, 3'b010, 3'b000, 1'b0, 1'b0, 1'b0);
    rd("R6", 5'h03, 8'hF4);
    // R8 watchdog clear sets both
    cyc(1'b0, 5'h00, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1);
    rd("R8", 5'h03, 8'hFC);
    // R8 timeout clears TO
    cyc(1'b0, 5'h00, 8'h00, 3'b000, 3'b000, 1'b0, 1'b1, 1'b0);
    rd("R8", 5'h03, 8'hEC);
    // R8 clear and sleep together: sleep wins PD, TO set
    cyc(1'b0, 5'h00, 8'h00, 3'b000, 3'b000, 1'b1, 1'b0, 1'b1);
    rd("R8", 5'h03, 8'hF4);
    // R3 indirect write reaching the condition register
    cyc(1'b1, 5'h04, 8'h03, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 5'h00, 8'h00, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
    rd("R3", 5'h03, 8'h10);
    rd("R3", 5'h00, 8'h10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule